// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a burst-capable cache memory. A start address is captured when either of two independent address strobes is asserted: one driven by the processor, one by the cache controller. After that, each cycle with the advance input asserted steps an internal 2-bit beat counter. The low two address bits are then rebuilt from the captured start bits and the counter, so that a burst covers four words. The upper address bits pass through unchanged from the captured address.

A static mode input selects how the four words are ordered. With linear ordering the low bits count upward from the start value and wrap modulo 4. With interleaved ordering the low bits are the start value XOR the beat count, which is the order some processors expect for cache-line fills. All strobe, advance and address inputs act only at the rising clock edge. The mode input is treated as a static strap and acts directly on the output.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe or advance seen yet, addrOut is all zeros.
- R2: A clock edge with strobeCpu or strobeCtl high (either one, or both) captures addrIn. From the next cycle addrOut equals addrIn exactly, in either mode.
- R3: With modeInterleave = 0 (linear), after n advances since the last load, the low two bits of addrOut equal (start low bits + n) mod 4.
- R4: With modeInterleave = 1 (interleaved), after n advances since the last load, the low two bits of addrOut equal start low bits XOR (n mod 4).
- R5: A clock edge with both strobes and advance low leaves addrOut unchanged, whatever value addrIn has.
- R6: A fourth advance after a load returns addrOut to the captured start address, and no new load is needed.
- R7: When a strobe and advance are high at the same edge, the strobe wins: addrOut becomes addrIn and the beat count restarts at zero.
- R8: Advances never change addrOut bits above bit 1. Those bits only change on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W (15) | External start address |
| strobeCpu | input | 1 | Processor address strobe, active high |
| strobeCtl | input | 1 | Controller address strobe, active high |
| advance | input | 1 | Step to the next beat of the burst |
| modeInterleave | input | 1 | 1 = interleaved order, 0 = linear order |
| addrOut | output | ADDR_W (15) | Sequenced word address |

## Verification
Loading and stepping can be requested at the same edge. The bench provokes this by holding advance high together with each strobe in turn, partway through a burst that has already advanced. It judges the result by requiring the next output to equal the new addrIn exactly. The following advances must then run from beat zero of the new start value, not from the old count. The checker also follows the beat count independently, so the same collision is judged at every cycle where it occurs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Command from control to datapath; load and step are mutually exclusive.
  typedef struct packed {
    logic load;
    logic step;
  } seqCmd_t;
endpackage

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl
  import burst_seq_pkg::*;
(
  input  logic    strobeCpu,
  input  logic    strobeCtl,
  input  logic    advance,
  output seqCmd_t cmd
);
  logic anyStrobe;

  assign anyStrobe = strobeCpu | strobeCtl;

  // A strobe outranks advance in the same cycle.
  always_comb begin
    cmd.load = anyStrobe;
    cmd.step = advance & ~anyStrobe;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  linSum;
  logic [CNT_W-1:0]  lowSeq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else if (cmd.load) begin
      baseQ <= addrIn;
      cntQ  <= '0;
    end else if (cmd.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  assign linSum = baseQ[CNT_W-1:0] + cntQ;

  // Per-bit selection between linear and interleaved ordering.
  for (genvar b = 0; b < CNT_W; b++) begin : g_lane
    assign lowSeq[b] = modeInterleave ? (baseQ[b] ^ cntQ[b]) : linSum[b];
  end

  if (HI_W > 0) begin : g_upper
    assign addrOut = {baseQ[ADDR_W-1:CNT_W], lowSeq};
  end else begin : g_noUpper
    assign addrOut = lowSeq;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              strobeCpu,
  input  logic              strobeCtl,
  input  logic              advance,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] addrOut
);
  seqCmd_t seqCmd;

  burst_seq_ctl u_ctl (
    .strobeCpu (strobeCpu),
    .strobeCtl (strobeCtl),
    .advance   (advance),
    .cmd       (seqCmd)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .cmd            (seqCmd),
    .addrIn         (addrIn),
    .modeInterleave (modeInterleave),
    .addrOut        (addrOut)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              strobeCpu,
  input logic              strobeCtl,
  input logic              advance,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] addrOut
);
  logic             anyStb;
  logic [CNT_W-1:0] refStart;
  logic [CNT_W-1:0] refCnt;
  logic [CNT_W-1:0] refLow;

  assign anyStb = strobeCpu | strobeCtl;

  // Independent tracking of start bits and beat count, seen from the ports.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refStart <= '0;
      refCnt   <= '0;
    end else if (anyStb) begin
      refStart <= addrIn[CNT_W-1:0];
      refCnt   <= '0;
    end else if (advance) begin
      refCnt   <= refCnt + 1'b1;
    end
  end

  assign refLow = modeInterleave ? (refStart ^ refCnt) : (refStart + refCnt);

  p_reset_zero_r1: assert property (@(posedge clk) $rose(rstN) |-> addrOut == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |=> addrOut == $past(addrIn));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStb && advance && !modeInterleave) |=>
      (modeInterleave || addrOut[CNT_W-1:0] == $past(addrOut[CNT_W-1:0]) + 1'b1));

  p_sequence_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrOut[CNT_W-1:0] == refLow);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStb && !advance) |=>
      (modeInterleave != $past(modeInterleave) || addrOut == $past(addrOut)));

  p_strobe_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && advance) |=> addrOut == $past(addrIn));

  p_upper_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !anyStb |=> addrOut[ADDR_W-1:CNT_W] == $past(addrOut[ADDR_W-1:CNT_W]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .addrIn         (addrIn),
  .strobeCpu      (strobeCpu),
  .strobeCtl      (strobeCtl),
  .advance        (advance),
  .modeInterleave (modeInterleave),
  .addrOut        (addrOut)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          strobeCpu = 1'b0;
  logic          strobeCtl = 1'b0;
  logic          advance = 1'b0;
  logic          modeInterleave = 1'b0;
  logic [AW-1:0] addrOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .strobeCpu(strobeCpu),
    .strobeCtl(strobeCtl), .advance(advance), .modeInterleave(modeInterleave),
    .addrOut(addrOut)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample 1 ns later.
  task automatic cyc(input logic cpu, input logic ctl, input logic adv, input logic [AW-1:0] a);
    @(negedge clk);
    strobeCpu = cpu; strobeCtl = ctl; advance = adv; addrIn = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] s, input int n, input logic il);
    logic [1:0] nb;
    logic [1:0] low;
    nb  = 2'(n);
    low = il ? (s[1:0] ^ nb) : (s[1:0] + nb);
    return {s[AW-1:2], low};
  endfunction

  task automatic t_reset();
    #1 check("R1 during reset", addrOut, '0);
    @(negedge clk); rstN = 1'b1;
    cyc(0, 0, 0, 15'h1234);
    check("R1 after reset", addrOut, '0);
  endtask

  task automatic t_load();
    modeInterleave = 1'b0;
    cyc(1, 0, 0, 15'h2A5D); check("R2 cpu strobe", addrOut, 15'h2A5D);
    modeInterleave = 1'b1;
    cyc(0, 1, 0, 15'h1003); check("R2 ctl strobe", addrOut, 15'h1003);
    cyc(1, 1, 0, 15'h7FFE); check("R2 both strobes", addrOut, 15'h7FFE);
  endtask

  task automatic t_linear(input logic [AW-1:0] s);
    modeInterleave = 1'b0;
    cyc(1, 0, 0, s);
    for (int n = 1; n < 4; n++) begin
      cyc(0, 0, 1, 15'h0);
      check($sformatf("R3 linear beat %0d", n), addrOut, expAddr(s, n, 1'b0));
      check("R8 upper bits linear", {addrOut[AW-1:2], 2'b00}, {s[AW-1:2], 2'b00});
    end
  endtask

  task automatic t_interleave(input logic [AW-1:0] s);
    modeInterleave = 1'b1;
    cyc(0, 1, 0, s);
    for (int n = 1; n < 4; n++) begin
      cyc(0, 0, 1, 15'h7FFF);
      check($sformatf("R4 interleave beat %0d", n), addrOut, expAddr(s, n, 1'b1));
    end
  endtask

  task automatic t_hold();
    logic [AW-1:0] s;
    s = 15'h0C41;
    modeInterleave = 1'b0;
    cyc(1, 0, 0, s);
    cyc(0, 0, 1, 15'h0);
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 15'h5555 + 15'(k));
      check("R5 hold", addrOut, expAddr(s, 1, 1'b0));
    end
    cyc(0, 0, 1, 15'h0);
    check("R5 resume after hold", addrOut, expAddr(s, 2, 1'b0));
  endtask

  task automatic t_wrap(input logic il, input logic [AW-1:0] s);
    modeInterleave = il;
    cyc(1, 0, 0, s);
    for (int n = 1; n <= 5; n++) cyc(0, 0, 1, 15'h0);
    check("R6 wrap beat 5", addrOut, expAddr(s, 5, il));
    modeInterleave = il;
    cyc(1, 0, 0, s);
    for (int n = 1; n <= 4; n++) cyc(0, 0, 1, 15'h0);
    check("R6 wrap to start", addrOut, s);
  endtask

  task automatic t_priority();
    modeInterleave = 1'b1;
    cyc(1, 0, 0, 15'h0101);
    cyc(0, 0, 1, 15'h0);
    cyc(0, 0, 1, 15'h0);
    cyc(1, 0, 1, 15'h3332);
    check("R7 cpu strobe beats advance", addrOut, 15'h3332);
    cyc(0, 0, 1, 15'h0);
    check("R7 count restarted", addrOut, expAddr(15'h3332, 1, 1'b1));
    modeInterleave = 1'b0;
    cyc(0, 1, 1, 15'h4447);
    check("R7 ctl strobe beats advance", addrOut, 15'h4447);
    cyc(0, 0, 1, 15'h0);
    check("R7 linear after reload", addrOut, expAddr(15'h4447, 1, 1'b0));
  endtask

  initial begin
    t_reset();
    t_load();
    t_linear(15'h1232);
    t_linear(15'h7FFF);
    t_interleave(15'h0A01);
    t_interleave(15'h2222);
    t_hold();
    t_wrap(1'b0, 15'h0F02);
    t_wrap(1'b1, 15'h3013);
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule